// File: doc/BRIEF.md
# Configuration Register Bank with Serial and Parallel Write Ports

This block keeps the settings that steer an image-sensor front end: one 8-bit configuration word, a 10-bit offset code for each of the red, green and blue channels, and a 5-bit gain code for each channel. Software can reach the bank in two ways. The first is a 3-wire serial port that only accepts writes. The second is a parallel port with a 3-bit address, a 10-bit data word and separate read and write strobes. The parallel port shares a data bus with the converter output, so the bank produces a data word, a bus enable and an enable for the converter's own output drivers.

Two mode pins select who may use the bus. `drv_off` turns the converter's output drivers off. `par_sel` selects the parallel port. Setting configuration bit 7 puts the output into demultiplexed mode, and this bit shuts the parallel port until a serial write clears it. The serial pins run with no relation to the system clock. They are brought into the clock domain through synchronisers before any bit is shifted in. Each offset code is also provided as a signed trim value centred on zero.

Top module: `cfg_regbank_port`

## Requirements
- R1: While reset is low and after it is released, every register reads zero, so every signed trim reads -512, and the parallel bus enable stays low.
- R2: A serial frame is the sequence of bits sampled on rising edges of `ser_clk`, most significant first: 3 address bits and then 10 data bits. A rising edge of `ser_wr` commits the frame. If more than 13 bits arrived, the last 13 are used.
- R3: If `ser_wr` rises after fewer than 13 bits, the frame is discarded and no register changes. The bit count starts again from zero.
- R4: The address map is 0 = configuration, 1/2/3 = red/green/blue offset, 4/5/6 = red/green/blue gain. A write stores only the low bits that fit the target register.
- R5: A write to address 7 changes no register. A parallel read of address 7 returns zero.
- R6: The mode pair {drv_off, par_sel} decodes as follows. 00: serial writes allowed and `adc_out_en` high. 01: no access at all and `adc_out_en` low. 10: serial writes allowed and `adc_out_en` low. 11: parallel access with `adc_out_en` low.
- R7: In mode 11, a rising edge of `par_wr` writes `par_din` to `par_addr` at the clock edge that first sees it high. In any other mode it has no effect.
- R8: In mode 11 with `par_rd` high, `par_dout_en` is high and `par_dout` carries the addressed register zero-extended, in the same cycle. At all other times `par_dout_en` is low and `par_dout` is zero.
- R9: While configuration bit 7 is 1, parallel reads and writes are refused.
- R10: Serial strobes have no effect while `par_sel` is high, and the serial bit count is held at zero.
- R11: Each signed offset trim equals its offset code minus 512, in two's complement (code 0x200 gives zero).
- R12: A serial commit is visible at the register outputs on the third clock edge after `ser_wr` rises (two synchroniser stages plus the edge detector).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_off | input | 1 | Converter output drivers off when 1 |
| par_sel | input | 1 | Select parallel port when 1 |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data, asynchronous |
| ser_wr | input | 1 | Serial commit strobe, asynchronous |
| par_wr | input | 1 | Parallel write strobe |
| par_rd | input | 1 | Parallel read strobe |
| par_addr | input | 3 | Parallel register address |
| par_din | input | 10 | Parallel write data |
| par_dout | output | 10 | Parallel read data |
| par_dout_en | output | 1 | Bank drives the shared bus when 1 |
| adc_out_en | output | 1 | Converter output drivers enabled |
| cfg_q | output | 8 | Configuration register |
| off_code | output | 30 | Offset codes, red at bits 9:0, then green, then blue |
| off_trim | output | 30 | Signed offsets, same packing |
| gain_code | output | 15 | Gain codes, red at bits 4:0, then green, then blue |

## Verification
The hardest case to reach is the path that recovers from parallel lockout. The bench first sets demultiplexed mode with a parallel write. It then shows that parallel writes and reads are refused, moves the mode pins to serial, and clears the bit with a full serial frame. The parallel port must come back after that. Short frames and frames that are too long are also driven, each followed by a correct frame. This shows that the bit count restarts after a discard and that only the last 13 bits are used.

// File: rtl/cfgport_pkg.sv
// Shared constants, types and mode decoding for the configuration register bank.
// Assumes the mode pins are synchronous to the system clock.
package cfgport_pkg;

    // Position of the demultiplexed-output flag inside the configuration word
    localparam int CFG_DEMUX_BIT = 7;

    // Access mode as {drv_off, par_sel}
    typedef enum logic [1:0] {
        ACC_SER_DRIVE = 2'b00,
        ACC_BLOCKED   = 2'b01,
        ACC_SER_QUIET = 2'b10,
        ACC_PARALLEL  = 2'b11
    } acc_mode_e;

    // Permissions derived from the access mode
    typedef struct packed {
        logic ser_ok;
        logic par_ok;
        logic out_en;
    } acc_perm_t;

    // Decode the mode pins and the demux flag into access permissions
    function automatic acc_perm_t decode_mode(input logic drv_off, input logic par_sel,
                                              input logic demux);
        acc_perm_t p;
        p = '0;
        unique case (acc_mode_e'({drv_off, par_sel}))
            ACC_SER_DRIVE: begin p.ser_ok = 1'b1; p.out_en = 1'b1; end
            ACC_SER_QUIET: p.ser_ok = 1'b1;
            ACC_PARALLEL:  p.par_ok = !demux;
            default:       p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ser_frame_rx.sv
// Serial write receiver: brings ser_clk, ser_din and ser_wr into the clock
// domain with matched synchronisers. It shifts one bit on each synchronised
// rising edge of ser_clk and emits one write when ser_wr rises after a full
// frame has arrived. Assumes each serial level is held for at least two
// system clocks. A short frame is dropped, and a long frame keeps its last bits.
module ser_frame_rx #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_wr,
    output logic              frame_fire,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [DATA_W-1:0] frame_data
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic [SYNC_STAGES-1:0] sclk_pipe, sdat_pipe, swr_pipe;
    logic                   sclk_last, swr_last;
    logic                   sclk_rise, swr_rise;
    logic [FRAME_W-1:0]     shreg;
    logic [CNT_W-1:0]       nbits;

    // Synchronise the three serial pins through equal-length chains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            sdat_pipe <= '0;
            swr_pipe  <= '0;
            sclk_last <= 1'b0;
            swr_last  <= 1'b0;
        end else begin
            sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], ser_clk};
            sdat_pipe <= {sdat_pipe[SYNC_STAGES-2:0], ser_din};
            swr_pipe  <= {swr_pipe[SYNC_STAGES-2:0], ser_wr};
            sclk_last <= sclk_pipe[SYNC_STAGES-1];
            swr_last  <= swr_pipe[SYNC_STAGES-1];
        end
    end

    // Edge detection on the synchronised strobes
    always_comb begin
        sclk_rise = sclk_pipe[SYNC_STAGES-1] & ~sclk_last;
        swr_rise  = swr_pipe[SYNC_STAGES-1] & ~swr_last;
    end

    // Shift register and saturating bit count; a commit or a disabled port restarts the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            nbits <= '0;
        end else if (!enable || swr_rise) begin
            nbits <= '0;
        end else if (sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], sdat_pipe[SYNC_STAGES-1]};
            if (nbits != FULL) nbits <= nbits + 1'b1;
        end
    end

    // A commit counts only when a complete frame is held
    always_comb begin
        frame_fire = enable & swr_rise & (nbits == FULL);
        frame_addr = shreg[FRAME_W-1 -: ADDR_W];
        frame_data = shreg[DATA_W-1:0];
    end

endmodule

// File: rtl/par_access.sv
// Parallel port: turns a rising edge of par_wr into a single write and puts
// the read data on the bus while par_rd is high. Assumes the strobes and the
// address are synchronous to clk. Both actions are gated by 'allow'.
module par_access #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow,
    input  logic              par_wr,
    input  logic              par_rd,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_fire,
    output logic              dout_en,
    output logic [DATA_W-1:0] dout
);
    logic wr_last;

    // Remember the previous write strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) wr_last <= 1'b0;
        else        wr_last <= par_wr;
    end

    // Write pulse and bus drive, both gated by permission
    always_comb begin
        wr_fire = allow & par_wr & ~wr_last;
        dout_en = allow & par_rd;
        dout    = dout_en ? rd_data : '0;
    end

endmodule

// File: rtl/reg_store.sv
// Register storage: one configuration word and a per-channel offset and gain.
// Address 0 selects the configuration word, then come the offsets by channel
// and then the gains by channel. Any other address is reserved. Writes keep
// only the low bits that fit, and reads are zero-extended to DATA_W.
module reg_store #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 10,
    parameter int CFG_W  = 8,
    parameter int OFF_W  = 10,
    parameter int GAIN_W = 5,
    parameter int N_CH   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [CFG_W-1:0]         cfg_q,
    output logic [N_CH*OFF_W-1:0]    off_code,
    output logic [N_CH*OFF_W-1:0]    off_trim,
    output logic [N_CH*GAIN_W-1:0]   gain_code
);
    localparam int OFF_BASE  = 1;
    localparam int GAIN_BASE = 1 + N_CH;

    logic [OFF_W-1:0]  off_q  [N_CH];
    logic [GAIN_W-1:0] gain_q [N_CH];

    // Configuration word
    always_ff @(posedge clk) begin
        if (!rst_n)                    cfg_q <= '0;
        else if (wr_en && wr_addr == '0) cfg_q <= wr_data[CFG_W-1:0];
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        localparam logic [ADDR_W-1:0] OFF_A  = ADDR_W'(OFF_BASE + ch);
        localparam logic [ADDR_W-1:0] GAIN_A = ADDR_W'(GAIN_BASE + ch);

        // Per-channel offset code
        always_ff @(posedge clk) begin
            if (!rst_n)                       off_q[ch] <= '0;
            else if (wr_en && wr_addr == OFF_A) off_q[ch] <= wr_data[OFF_W-1:0];
        end

        // Per-channel gain code
        always_ff @(posedge clk) begin
            if (!rst_n)                        gain_q[ch] <= '0;
            else if (wr_en && wr_addr == GAIN_A) gain_q[ch] <= wr_data[GAIN_W-1:0];
        end

        // Flatten the channel registers; the trim flips the offset-binary MSB into two's complement
        assign off_code[ch*OFF_W +: OFF_W]   = off_q[ch];
        assign off_trim[ch*OFF_W +: OFF_W]   = {~off_q[ch][OFF_W-1], off_q[ch][OFF_W-2:0]};
        assign gain_code[ch*GAIN_W +: GAIN_W] = gain_q[ch];
    end

    // Read multiplexer; reserved addresses read zero
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data = DATA_W'(cfg_q);
        for (int ch = 0; ch < N_CH; ch++) begin
            if (rd_addr == ADDR_W'(OFF_BASE + ch))  rd_data = DATA_W'(off_q[ch]);
            if (rd_addr == ADDR_W'(GAIN_BASE + ch)) rd_data = DATA_W'(gain_q[ch]);
        end
    end

endmodule

// File: rtl/cfg_regbank_port.sv
// Top of the configuration register bank. It decodes the access mode, takes
// writes from the serial receiver or the parallel port (never both, because
// the modes exclude each other) and provides the registers to the datapath.
// Assumes clk drives all synchronous inputs and the serial pins are asynchronous.
module cfg_regbank_port #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 10,
    parameter int CFG_W       = 8,
    parameter int OFF_W       = 10,
    parameter int GAIN_W      = 5,
    parameter int N_CH        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   drv_off,
    input  logic                   par_sel,
    input  logic                   ser_clk,
    input  logic                   ser_din,
    input  logic                   ser_wr,
    input  logic                   par_wr,
    input  logic                   par_rd,
    input  logic [ADDR_W-1:0]      par_addr,
    input  logic [DATA_W-1:0]      par_din,
    output logic [DATA_W-1:0]      par_dout,
    output logic                   par_dout_en,
    output logic                   adc_out_en,
    output logic [CFG_W-1:0]       cfg_q,
    output logic [N_CH*OFF_W-1:0]  off_code,
    output logic [N_CH*OFF_W-1:0]  off_trim,
    output logic [N_CH*GAIN_W-1:0] gain_code
);
    import cfgport_pkg::*;

    acc_perm_t         perm;
    logic              ser_fire, par_fire, wr_fire;
    logic [ADDR_W-1:0] ser_addr, wr_addr;
    logic [DATA_W-1:0] ser_data, wr_data, rd_data;

    // Access permissions from the mode pins and the demux flag
    always_comb begin
        perm       = decode_mode(drv_off, par_sel, cfg_q[CFG_DEMUX_BIT]);
        adc_out_en = perm.out_en;
    end

    ser_frame_rx #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .enable(perm.ser_ok),
        .ser_clk(ser_clk), .ser_din(ser_din), .ser_wr(ser_wr),
        .frame_fire(ser_fire), .frame_addr(ser_addr), .frame_data(ser_data)
    );

    par_access #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_par (
        .clk(clk), .rst_n(rst_n), .allow(perm.par_ok),
        .par_wr(par_wr), .par_rd(par_rd), .rd_data(rd_data),
        .wr_fire(par_fire), .dout_en(par_dout_en), .dout(par_dout)
    );

    // Select the write source; the permissions never let both fire together
    always_comb begin
        wr_fire = ser_fire | par_fire;
        wr_addr = par_fire ? par_addr : ser_addr;
        wr_data = par_fire ? par_din  : ser_data;
    end

    reg_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W),
        .OFF_W(OFF_W), .GAIN_W(GAIN_W), .N_CH(N_CH)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(par_addr), .rd_data(rd_data),
        .cfg_q(cfg_q), .off_code(off_code), .off_trim(off_trim), .gain_code(gain_code)
    );

endmodule

// File: rtl/cfg_regbank_chk.sv
// Property checker for cfg_regbank_port, attached to it by the bind below.
// It observes the ports and the internal write strobe between the write
// sources and the register store.
module cfg_regbank_chk #(
    parameter int ADDR_W = 3,
    parameter int CFG_W  = 8,
    parameter int OFF_W  = 10,
    parameter int GAIN_W = 5,
    parameter int N_CH   = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   drv_off,
    input logic                   par_sel,
    input logic                   par_dout_en,
    input logic                   adc_out_en,
    input logic [CFG_W-1:0]       cfg_q,
    input logic [N_CH*OFF_W-1:0]  off_code,
    input logic [N_CH*GAIN_W-1:0] gain_code,
    input logic                   wr_fire,
    input logic [ADDR_W-1:0]      wr_addr
);
    localparam logic [ADDR_W-1:0] RSV_A = ADDR_W'(2 * N_CH + 1);

    // R9
    demux_locks_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[cfgport_pkg::CFG_DEMUX_BIT] |-> !par_dout_en);

    // R8
    bus_no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_dout_en |-> !adc_out_en);

    // R6
    forbidden_mode_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && !drv_off) |-> !wr_fire);

    // R5
    reserved_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_addr == RSV_A) |=> ($stable(cfg_q) && $stable(off_code) && $stable(gain_code)));

    // R4
    cfg_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(wr_fire && wr_addr == '0));

endmodule

bind cfg_regbank_port cfg_regbank_chk #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .OFF_W(OFF_W), .GAIN_W(GAIN_W), .N_CH(N_CH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .drv_off(drv_off), .par_sel(par_sel),
    .par_dout_en(par_dout_en), .adc_out_en(adc_out_en), .cfg_q(cfg_q),
    .off_code(off_code), .gain_code(gain_code), .wr_fire(wr_fire), .wr_addr(wr_addr)
);

// File: tb/test_cfg_regbank_port.sv
`timescale 1ns/100ps
// Bench: a behavioural model of the register bank, compared on every clock.
module test_cfg_regbank_port;
    localparam int LAT = 3; // two synchroniser stages plus edge detector (R12)

    logic clk = 0, rst_n = 0;
    logic drv_off = 0, par_sel = 0, ser_clk = 0, ser_din = 0, ser_wr = 0;
    logic par_wr = 0, par_rd = 0;
    logic [2:0] par_addr = 0;
    logic [9:0] par_din = 0;
    logic [9:0] par_dout;
    logic par_dout_en, adc_out_en;
    logic [7:0] cfg_q;
    logic [29:0] off_code, off_trim;
    logic [14:0] gain_code;

    always #2.5 clk = ~clk;

    cfg_regbank_port i_cfg_regbank_port (
        .clk(clk), .rst_n(rst_n), .drv_off(drv_off), .par_sel(par_sel),
        .ser_clk(ser_clk), .ser_din(ser_din), .ser_wr(ser_wr),
        .par_wr(par_wr), .par_rd(par_rd), .par_addr(par_addr), .par_din(par_din),
        .par_dout(par_dout), .par_dout_en(par_dout_en), .adc_out_en(adc_out_en),
        .cfg_q(cfg_q), .off_code(off_code), .off_trim(off_trim), .gain_code(gain_code)
    );

    int vecs = 0, errs = 0;
    string cur_req = "R1";
    int m_cfg = 0;
    int m_off[3] = '{0, 0, 0};
    int m_gain[3] = '{0, 0, 0};
    int pend = 0, p_addr = 0, p_data = 0;
    bit bitq[$];
    bit done = 0;

    task automatic check(string req, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void apply(int a, int d);
        case (a)
            0: m_cfg = d & 'hFF;
            1, 2, 3: m_off[a-1] = d & 'h3FF;
            4, 5, 6: m_gain[a-4] = d & 'h1F;
            default: ; // reserved address: no change
        endcase
    endfunction

    function automatic int model_read(int a);
        case (a)
            0: return m_cfg;
            1, 2, 3: return m_off[a-1];
            4, 5, 6: return m_gain[a-4];
            default: return 0;
        endcase
    endfunction

    function automatic bit ser_allowed();
        return !par_sel;
    endfunction

    function automatic bit par_allowed();
        return drv_off && par_sel && !m_cfg[7];
    endfunction

    // One clock: advance the model, then compare every output
    task automatic tick();
        int exp_en;
        @(posedge clk); #1;
        if (pend > 0) begin
            pend--;
            if (pend == 0) apply(p_addr, p_data);
        end
        check(cur_req, cfg_q, m_cfg);
        for (int ch = 0; ch < 3; ch++) begin
            check(cur_req, off_code[ch*10 +: 10], m_off[ch]);
            check({"R11/", cur_req}, off_trim[ch*10 +: 10], m_off[ch] ^ 'h200);
            check(cur_req, gain_code[ch*5 +: 5], m_gain[ch]);
        end
        exp_en = (rst_n && par_allowed() && par_rd) ? 1 : 0;
        check({"R8/", cur_req}, par_dout_en, exp_en);
        check({"R8/", cur_req}, par_dout, exp_en ? model_read(par_addr) : 0);
        check({"R6/", cur_req}, adc_out_en, (!drv_off && !par_sel) ? 1 : 0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_mode(logic d, logic p);
        drv_off = d;
        par_sel = p;
        if (p) bitq.delete(); // R10: count held at zero
        ticks(2);
    endtask

    task automatic ser_send(int nb, logic [15:0] v);
        for (int i = nb - 1; i >= 0; i--) begin
            ser_din = v[i];
            ticks(2);
            ser_clk = 1;
            if (ser_allowed()) bitq.push_back(v[i]);
            ticks(3);
            ser_clk = 0;
            ticks(3);
        end
    endtask

    task automatic ser_commit();
        logic [12:0] fr;
        ser_wr = 1;
        if (ser_allowed()) begin
            if (bitq.size() >= 13) begin
                fr = '0;
                for (int i = 0; i < 13; i++) fr[12-i] = bitq[bitq.size() - 13 + i];
                p_addr = fr[12:10];
                p_data = fr[9:0];
                pend = LAT;
            end
            bitq.delete();
        end
        ticks(4);
        ser_wr = 0;
        ticks(3);
    endtask

    task automatic ser_frame(int a, int d);
        ser_send(13, {3'b000, 3'(a), 10'(d)});
        ser_commit();
    endtask

    task automatic par_write(int a, int d);
        par_addr = 3'(a);
        par_din = 10'(d);
        par_wr = 1;
        if (par_allowed()) begin
            p_addr = a;
            p_data = d;
            pend = 1;
        end
        ticks(2);
        par_wr = 0;
        ticks(1);
    endtask

    task automatic par_read(int a);
        par_addr = 3'(a);
        par_rd = 1;
        ticks(1);
        par_rd = 0;
        ticks(1);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        ticks(4);
        rst_n = 1;
        ticks(3);

        // R2 R4 R12: serial writes to every register, with truncation
        cur_req = "R2 R4 R12";
        ser_frame(1, 'h3FF);
        ser_frame(2, 'h155);
        ser_frame(3, 'h200);
        ser_frame(4, 'h3FF);
        ser_frame(5, 'h3EA);
        ser_frame(6, 'h015);
        ser_frame(0, 'h35A);

        // R3: short frame dropped, next full frame accepted
        cur_req = "R3";
        ser_send(12, 16'({3'd1, 10'h0AB}) >> 1);
        ser_commit();
        ser_frame(2, 'h0F0);

        // R2: long frame keeps the last 13 bits
        cur_req = "R2";
        ser_send(15, {3'b011, 3'd6, 10'h00C});

        ser_commit();

        // R5: reserved address write ignored
        cur_req = "R5";
        ser_frame(7, 'h3FF);

        // R6: mode 10 accepts serial with outputs off
        cur_req = "R6";
        set_mode(1, 0);
        ser_frame(3, 'h001);

        // R6 R10: mode 01 blocks everything
        cur_req = "R6 R10";
        set_mode(0, 1);
        ser_frame(1, 'h123);
        par_write(4, 'h07);
        par_read(1);

        // R10: serial ignored in parallel mode
        cur_req = "R10";
        set_mode(1, 1);
        ser_frame(1, 'h124);

        // R7 R8 R5: parallel writes and reads
        cur_req = "R7";
        par_write(1, 'h2AA);
        par_write(5, 'h3F3);
        par_write(7, 'h3FF);
        cur_req = "R8 R5";
        for (int a = 0; a < 8; a++) par_read(a);

        // R9: demux flag locks the parallel port
        cur_req = "R9";
        par_write(0, 'h080);
        par_write(4, 'h01);
        par_read(0);
        par_read(4);

        // R9: serial clears the flag, parallel access returns
        set_mode(0, 0);
        ser_frame(0, 'h003);
        set_mode(1, 1);
        par_write(6, 'h11);
        par_read(6);
        par_read(0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    // Watchdog
    initial begin
        #(5 * 150000);
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule